// File: doc/BRIEF.md
# Dual-Read General Register File with Selectable Stack/Zero Index

This block holds the integer working registers of a 64-bit processor core. There are thirty-one numbered entries, plus one top index whose meaning is chosen on each access. When an access raises its stack flag, the top index reaches a dedicated stack-pointer register. Without that flag, the top index is a constant zero source and a sink that drops whatever is written to it.

Two combinational read ports each deliver a 64-bit result. That result is either the whole register or its low 32, 16 or 8 bits, zero- or sign-extended as the access asks. A single write port commits on the rising clock edge, either the whole 64-bit word or a 32-bit word that also clears the upper half of the destination. A read of the entry being written in the same cycle returns the value stored before the write. A synchronous active-high reset clears every entry and the stack pointer.

Top module: `gpr_file`

## Requirements
- R1: After reset every numbered register and the stack pointer read as zero.
- R2: A 64-bit write (wr_wide=1) to index 0..30 replaces all 64 bits of that register at the next rising edge.
- R3: A 32-bit write (wr_wide=0) stores wr_data[31:0] into bits 31:0 and forces bits 63:32 of the destination to zero.
- R4: Index 31 with the stack flag set addresses the stack pointer for both reads and writes. The stack pointer is separate storage, and a write to it leaves registers 0..30 unchanged.
- R5: Index 31 with the stack flag clear reads as zero on any port, in every size mode.
- R6: A write to index 31 with the stack flag clear changes no register, and the stack pointer also stays unchanged.
- R7: Read size encoding is 2'b00=64, 2'b01=32, 2'b10=16, 2'b11=8 bits. The low bits of the register are returned. With the sign flag clear they are zero-extended, and with it set they are sign-extended to 64 bits.
- R8: A read of the register being written in the same cycle returns the old value. The new value is visible after the edge.
- R9: With wr_en low, no storage changes.
- R10: Both read ports work independently and may select different registers, sizes and modes in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_idx | input | 5 | Write index |
| wr_use_sp | input | 1 | Index 31 means stack pointer on write |
| wr_wide | input | 1 | 1: 64-bit write, 0: 32-bit write with upper clear |
| wr_data | input | 64 | Write data |
| ra_idx | input | 5 | Port A index |
| ra_use_sp | input | 1 | Port A stack-pointer select |
| ra_size | input | 2 | Port A size code |
| ra_signed | input | 1 | Port A sign extension |
| ra_data | output | 64 | Port A result |
| rb_idx | input | 5 | Port B index |
| rb_use_sp | input | 1 | Port B stack-pointer select |
| rb_size | input | 2 | Port B size code |
| rb_signed | input | 1 | Port B sign extension |
| rb_data | output | 64 | Port B result |

## Verification
The bench writes distinct patterns to every register and reads them back through both ports in all eight size/sign combinations. This catches a wrong extension, a wrong slice, or a port wired to the other port's index. It writes to the zero index and then checks all thirty-two storage locations. A design that stored into a shared slot would show the value as a nonzero zero-read or a disturbed stack pointer. It issues 32-bit writes over registers full of ones, which exposes a design that merges rather than clears the upper half. It also reads during writes, which exposes any write-through path.

// File: rtl/gpr_pkg.sv
package gpr_pkg;
  typedef enum logic [1:0] {
    SZ_DWORD = 2'b00,
    SZ_WORD  = 2'b01,
    SZ_HALF  = 2'b10,
    SZ_BYTE  = 2'b11
  } rd_size_e;

  function automatic logic [63:0] shape_read(input logic [63:0] raw,
                                             input rd_size_e sz,
                                             input logic sgn);
    logic [63:0] r;
    case (sz)
      SZ_WORD: r = sgn ? {{32{raw[31]}}, raw[31:0]} : {32'd0, raw[31:0]};
      SZ_HALF: r = sgn ? {{48{raw[15]}}, raw[15:0]} : {48'd0, raw[15:0]};
      SZ_BYTE: r = sgn ? {{56{raw[7]}},  raw[7:0]}  : {56'd0, raw[7:0]};
      default: r = raw;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/gpr_read_port.sv
module gpr_read_port
  import gpr_pkg::*;
#(
  parameter int XLEN  = 64,
  parameter int NREGS = 31,
  localparam int IW   = $clog2(NREGS + 1)
) (
  input  logic [NREGS-1:0][XLEN-1:0] regs,
  input  logic [XLEN-1:0]            sp_val,
  input  logic [IW-1:0]              idx,
  input  logic                       use_sp,
  input  logic [1:0]                 size,
  input  logic                       sgn,
  output logic [XLEN-1:0]            data
);
  logic [XLEN-1:0] raw;
  always_comb begin
    if (int'(idx) == NREGS) raw = use_sp ? sp_val : '0;
    else                    raw = regs[idx];
    data = shape_read(raw, rd_size_e'(size), sgn);
  end
endmodule

// File: rtl/gpr_write_ctl.sv
module gpr_write_ctl #(
  parameter int XLEN  = 64,
  parameter int NREGS = 31,
  localparam int IW   = $clog2(NREGS + 1)
) (
  input  logic              wr_en,
  input  logic [IW-1:0]     wr_idx,
  input  logic              wr_use_sp,
  input  logic              wr_wide,
  input  logic [XLEN-1:0]   wr_data,
  output logic [NREGS-1:0]  reg_we,
  output logic              sp_we,
  output logic [XLEN-1:0]   wdata
);
  localparam int HALF = XLEN / 2;
  always_comb begin
    wdata  = wr_wide ? wr_data : {{(XLEN-HALF){1'b0}}, wr_data[HALF-1:0]};
    reg_we = '0;
    sp_we  = 1'b0;
    if (wr_en) begin
      if (int'(wr_idx) == NREGS) sp_we = wr_use_sp;
      else                       reg_we[wr_idx] = 1'b1;
    end
  end
endmodule

// File: rtl/gpr_file.sv
module gpr_file #(
  parameter int XLEN  = 64,
  parameter int NREGS = 31,
  localparam int IW   = $clog2(NREGS + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [IW-1:0]   wr_idx,
  input  logic            wr_use_sp,
  input  logic            wr_wide,
  input  logic [XLEN-1:0] wr_data,
  input  logic [IW-1:0]   ra_idx,
  input  logic            ra_use_sp,
  input  logic [1:0]      ra_size,
  input  logic            ra_signed,
  output logic [XLEN-1:0] ra_data,
  input  logic [IW-1:0]   rb_idx,
  input  logic            rb_use_sp,
  input  logic [1:0]      rb_size,
  input  logic            rb_signed,
  output logic [XLEN-1:0] rb_data
);
  logic [NREGS-1:0][XLEN-1:0] regs;
  logic [XLEN-1:0]            sp_q;
  logic [NREGS-1:0]           reg_we;
  logic                       sp_we;
  logic [XLEN-1:0]            wdata;

  gpr_write_ctl #(.XLEN(XLEN), .NREGS(NREGS)) u_wctl (
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_use_sp(wr_use_sp), .wr_wide(wr_wide),
    .wr_data(wr_data), .reg_we(reg_we), .sp_we(sp_we), .wdata(wdata)
  );

  for (genvar g = 0; g < NREGS; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)            regs[g] <= '0;
      else if (reg_we[g]) regs[g] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        sp_q <= '0;
    else if (sp_we) sp_q <= wdata;
  end

  gpr_read_port #(.XLEN(XLEN), .NREGS(NREGS)) u_rda (
    .regs(regs), .sp_val(sp_q), .idx(ra_idx), .use_sp(ra_use_sp),
    .size(ra_size), .sgn(ra_signed), .data(ra_data)
  );
  gpr_read_port #(.XLEN(XLEN), .NREGS(NREGS)) u_rdb (
    .regs(regs), .sp_val(sp_q), .idx(rb_idx), .use_sp(rb_use_sp),
    .size(rb_size), .sgn(rb_signed), .data(rb_data)
  );
endmodule

// File: rtl/gpr_file_checker.sv
module gpr_file_checker #(
  parameter int XLEN  = 64,
  parameter int NREGS = 31,
  localparam int IW   = $clog2(NREGS + 1)
) (
  input logic            clk,
  input logic            rst,
  input logic            wr_en,
  input logic [IW-1:0]   wr_idx,
  input logic            wr_use_sp,
  input logic            wr_wide,
  input logic [XLEN-1:0] wr_data,
  input logic [IW-1:0]   ra_idx,
  input logic            ra_use_sp,
  input logic [1:0]      ra_size,
  input logic            ra_signed,
  input logic [XLEN-1:0] ra_data,
  input logic [IW-1:0]   rb_idx,
  input logic            rb_use_sp,
  input logic [XLEN-1:0] rb_data,
  input logic [XLEN-1:0] sp_q
);
  localparam int HALF = XLEN / 2;

  // R5: zero index reads zero on both ports
  assert_zero_read_a_R5: assert property (@(posedge clk) disable iff (rst)
    (int'(ra_idx) == NREGS && !ra_use_sp) |-> ra_data == '0);
  assert_zero_read_b_R5: assert property (@(posedge clk) disable iff (rst)
    (int'(rb_idx) == NREGS && !rb_use_sp) |-> rb_data == '0);
  // R6: discarded write leaves the stack pointer alone
  assert_zero_write_sp_R6: assert property (@(posedge clk) disable iff (rst)
    (wr_en && int'(wr_idx) == NREGS && !wr_use_sp) |=> $stable(sp_q));
  // R9: no write, stack pointer steady
  assert_idle_sp_R9: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(sp_q));
  // R4: stack write lands in the stack pointer
  assert_sp_write_R4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_wide && int'(wr_idx) == NREGS && wr_use_sp) |=> sp_q == $past(wr_data));
  // R3: narrow read-back of a 32-bit write has a clear upper half
  assert_narrow_upper_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_wide && int'(wr_idx) < NREGS && ra_idx == wr_idx && ra_size == 2'b00)
      |=> (ra_idx == $past(wr_idx) && ra_size == 2'b00) -> ra_data[XLEN-1:HALF] == '0);
  // R7: zero-extended byte read has clear upper bits
  assert_byte_zext_R7: assert property (@(posedge clk) disable iff (rst)
    (ra_size == 2'b11 && !ra_signed) |-> ra_data[XLEN-1:8] == '0);
endmodule

bind gpr_file gpr_file_checker #(.XLEN(XLEN), .NREGS(NREGS)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_use_sp(wr_use_sp),
  .wr_wide(wr_wide), .wr_data(wr_data), .ra_idx(ra_idx), .ra_use_sp(ra_use_sp),
  .ra_size(ra_size), .ra_signed(ra_signed), .ra_data(ra_data), .rb_idx(rb_idx),
  .rb_use_sp(rb_use_sp), .rb_data(rb_data), .sp_q(sp_q)
);

// File: tb/gpr_file_bench.sv
module gpr_file_bench;
  logic clk = 0, rst = 1;
  logic wr_en = 0, wr_use_sp = 0, wr_wide = 1;
  logic [4:0] wr_idx = 0, ra_idx = 0, rb_idx = 0;
  logic [63:0] wr_data = 0;
  logic ra_use_sp = 0, ra_signed = 0, rb_use_sp = 0, rb_signed = 0;
  logic [1:0] ra_size = 0, rb_size = 0;
  logic [63:0] ra_data, rb_data;
  int checks = 0, fails = 0;
  logic [63:0] model [32]; // 0..30 regs, 31 = stack pointer

  always #4 clk = ~clk;

  gpr_file u_gpr_file (.*);

  function automatic logic [63:0] expect_rd(logic [63:0] v, logic [1:0] sz, logic s);
    case (sz)
      2'b01: return s ? 64'($signed(v[31:0])) : 64'(v[31:0]);
      2'b10: return s ? 64'($signed(v[15:0])) : 64'(v[15:0]);
      2'b11: return s ? 64'($signed(v[7:0]))  : 64'(v[7:0]);
      default: return v;
    endcase
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] i, logic sp, logic wide, logic [63:0] d);
    wr_en = 1; wr_idx = i; wr_use_sp = sp; wr_wide = wide; wr_data = d;
    @(posedge clk); #1; wr_en = 0;
    if (i != 31) model[i] = wide ? d : {32'd0, d[31:0]};
    else if (sp) model[31] = wide ? d : {32'd0, d[31:0]};
  endtask

  task automatic rda(logic [4:0] i, logic sp, logic [1:0] sz, logic s);
    ra_idx = i; ra_use_sp = sp; ra_size = sz; ra_signed = s; #1;
  endtask

  task automatic sweep(string req);
    for (int i = 0; i < 32; i++) begin
      rda(5'(i), 1'b1, 2'b00, 1'b0);
      rb_idx = 5'(i); rb_use_sp = 1; rb_size = 0; rb_signed = 0; #1;
      chk(req, ra_data, model[i]);
      chk(req, rb_data, model[i]);
    end
  endtask

  initial begin
    #800000; fails++; $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 32; i++) model[i] = 0;
    repeat (3) @(posedge clk); #1; rst = 0;
    sweep("R1");
    // R2: 64-bit writes to all numbered regs plus SP (R4)
    for (int i = 0; i < 31; i++) wr(5'(i), 0, 1, {32'h8000_0000 | 32'(i * 32'h0101_0101), 32'hF0E1_8000 ^ 32'(i * 32'h0001_0081)});
    wr(31, 1, 1, 64'hDEAD_BEEF_CAFE_0031);
    sweep("R2 R4");
    // R7 / R10: all sizes, both ports
    for (int i = 0; i < 32; i++)
      for (int m = 0; m < 8; m++) begin
        rda(5'(i), 1'b1, 2'(m >> 1), 1'(m));
        rb_idx = 5'(31 - i); rb_use_sp = 1; rb_size = 2'(3 - (m >> 1)); rb_signed = ~1'(m); #1;
        chk("R7", ra_data, expect_rd(model[i], 2'(m >> 1), 1'(m)));
        chk("R10", rb_data, expect_rd(model[31 - i], 2'(3 - (m >> 1)), ~1'(m)));
      end
    // R5: zero index reads zero in every mode
    for (int m = 0; m < 8; m++) begin
      rda(31, 0, 2'(m >> 1), 1'(m));
      rb_idx = 31; rb_use_sp = 0; #1;
      chk("R5", ra_data, 64'd0); chk("R5", rb_data, 64'd0);
    end
    // R6: write to zero index discarded
    wr(31, 0, 1, 64'hFFFF_FFFF_FFFF_FFFF);
    wr(31, 0, 0, 64'h1234_5678_9ABC_DEF0);
    sweep("R6");
    rda(31, 0, 0, 0); chk("R6", ra_data, 64'd0);
    // R3: 32-bit writes over all-ones
    for (int i = 0; i < 31; i += 5) begin
      wr(5'(i), 0, 1, '1);
      wr(5'(i), 0, 0, 64'hAAAA_AAAA_8765_4321 + 64'(i));
      rda(5'(i), 0, 0, 0); chk("R3", ra_data, 64'h0000_0000_8765_4321 + 64'(i));
    end
    wr(31, 1, 1, '1); wr(31, 1, 0, 64'hFFFF_FFFF_0000_0077);
    rda(31, 1, 0, 0); chk("R3 R4", ra_data, 64'h77);
    // R8: read during write returns old value
    rda(7, 0, 0, 0);
    wr_en = 1; wr_idx = 7; wr_use_sp = 0; wr_wide = 1; wr_data = 64'h0BAD_F00D_0BAD_F00D; #1;
    chk("R8", ra_data, model[7]);
    @(posedge clk); #1; wr_en = 0; model[7] = 64'h0BAD_F00D_0BAD_F00D;
    chk("R8", ra_data, model[7]);
    // R9: wr_en low changes nothing
    wr_idx = 3; wr_data = 64'h5555; wr_wide = 1;
    repeat (3) @(posedge clk); #1;
    sweep("R9");
    // R1 again via reset
    rst = 1; @(posedge clk); #1; rst = 0;
    for (int i = 0; i < 32; i++) model[i] = 0;
    sweep("R1");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule